// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block sits behind the serial command front end of a small serial flash memory. The front end decodes each command and sends one pulse for it. The block keeps the 8-bit status byte and grants or refuses every command that would change stored contents. When it grants a command, it runs the self-timed busy period. For array operations it also sends a start strobe, with an operation code, to the array sequencer.

A write-class command is granted only when three things hold: the write-enable latch is set, the device is not busy, and the target is not protected. The target is protected by the block-protect field, and the status register itself is guarded by the hardware lock. The hardware lock is formed by the register-lock bit together with an active-low write-protect pin. Busy periods are counted in prescaled ticks, so a fast simulation can use short values. Persistent storage of the protect bits is not modelled: the register starts from its reset value.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte is 00h, `wip` is 0, and `cmd_accept`, `cmd_reject` and `array_start` are 0.
- R2: The status byte layout is: bit 7 register lock, bits 6:4 always 0, bits 3:2 protect field, bit 1 write-enable latch (WEL), bit 0 busy (equal to `wip`). Outside a busy period, `cmd_wren` sets WEL on the next clock and `cmd_wrdi` clears it.
- R3: A write-class command arriving while WEL is 0 gives a one-cycle `cmd_reject` on the next clock. It gives no `array_start` and leaves the status byte unchanged.
- R4: An accepted status write copies `wrsr_data` bits 7, 3 and 2 into status bits 7, 3 and 2 at the end of its busy period. All other data bits are ignored.
- R5: A status write is rejected while the lock bit is 1 and `wp_n` is 0. With the lock bit at 1 and `wp_n` at 1 it is accepted.
- R6: Protect field 00 protects nothing, 01 protects every address with the top address bit set, and 10 or 11 protect the whole array. Page program, sector erase and block erase aimed at a protected address are rejected.
- R7: Chip erase is accepted only when the protect field is 00.
- R8: On the clock after an accepted command, `cmd_accept` pulses and busy rises. Array commands also pulse `array_start`, with `array_op` set to 2 for page program, 3 for sector erase, 4 for block erase and 5 for chip erase. A status write gives no `array_start`.
- R9: Busy stays high for exactly its duration parameter times `TICK_DIV` clock cycles. WEL clears on the same clock edge on which busy clears.
- R10: While busy, write-class pulses are rejected, and `cmd_wren` and `cmd_wrdi` have no effect.
- R11: A rejected command leaves WEL unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Set-write-enable command pulse |
| cmd_wrdi | input | 1 | Clear-write-enable command pulse |
| cmd_wrsr | input | 1 | Status write command pulse |
| cmd_pp | input | 1 | Page program command pulse |
| cmd_se | input | 1 | Sector erase command pulse |
| cmd_be | input | 1 | Block erase command pulse |
| cmd_ce | input | 1 | Chip erase command pulse |
| addr | input | ADDR_W | Target byte address of the command |
| wrsr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Active-low write-protect pin |
| status | output | 8 | Status byte for the read-status path |
| cmd_accept | output | 1 | One-cycle grant of a write-class command |
| cmd_reject | output | 1 | One-cycle refusal of a write-class command |
| wip | output | 1 | Busy flag |
| array_start | output | 1 | One-cycle start strobe to the array sequencer |
| array_op | output | 3 | Array operation code, valid with `array_start` |

## Verification
A stuck or wrongly set WEL or protect field shows up on the very next write-class command. That command's accept or reject flag flips on the following clock, and the status byte shows the bad bit directly. A wrong busy count shows up as a busy period that is too short or too long at the end of the operation; the period is measured cycle by cycle against the duration parameter. A status update lost or misplaced at the end of a write shows up in the first status sample after busy falls. It also changes the outcome of the next protected program or erase.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WRSR = 3'd1,
        OP_PP   = 3'd2,
        OP_SE   = 3'd3,
        OP_BE   = 3'd4,
        OP_CE   = 3'd5
    } sg_op_e;

    typedef struct packed {
        logic       wel;
        logic       lock;
        logic [1:0] bp;
        logic [2:0] pend;    // {lock, bp} waiting for the end of a status write
        sg_op_e     run_op;  // operation owning the current busy period
        logic       accept;
        logic       reject;
        logic       start;
        sg_op_e     op;
    } sg_state_t;

endpackage

// File: rtl/sr_tick_gen.sv
module sr_tick_gen #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_pass;
            assign unused_pass = ^{clk, rst_n, restart};
            assign tick = 1'b1;
        end else begin : g_cnt
            localparam int unsigned W = $clog2(DIV);
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (restart || cnt_q == W'(DIV - 1)) cnt_d = '0;
                else                                 cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == W'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             busy_d, busy_q;

    assign done = busy_q && tick && (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (load) begin
            cnt_d  = load_val;
            busy_d = 1'b1;
        end else if (done) begin
            cnt_d  = '0;
            busy_d = 1'b0;
        end else if (busy_q && tick) begin
            cnt_d  = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/sr_prot_map.sv
module sr_prot_map (
    input  logic [1:0] bp,
    input  logic       upper,      // target lies in the upper half of the array
    output logic       region_prot,
    output logic       chip_ok
);
    always_comb begin
        unique case (bp)
            2'b00:   region_prot = 1'b0;
            2'b01:   region_prot = upper;
            default: region_prot = 1'b1;
        endcase
    end

    assign chip_ok = (bp == 2'b00);
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned TICK_DIV = 100,
    parameter int unsigned T_WRSR   = 5000,
    parameter int unsigned T_PP     = 600,
    parameter int unsigned T_SE     = 40000,
    parameter int unsigned T_BE     = 400000,
    parameter int unsigned T_CE     = 800000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wrsr_data,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              wip,
    output logic              array_start,
    output logic [2:0]        array_op
);
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned T_MAX = max2(max2(max2(T_WRSR, T_PP), max2(T_SE, T_BE)), T_CE);
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);

    sg_state_t        st_d, st_q;
    logic             tmr_busy, tmr_done, tick, load;
    logic             region_prot, chip_ok, hw_lock, wr_req, req_ok;
    sg_op_e           req_op;
    logic [CNT_W-1:0] load_val;
    logic             unused_in;

    assign unused_in = ^{wrsr_data[6:4], wrsr_data[1:0], addr[ADDR_W-2:0]};

    sr_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick)
    );

    sr_busy_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .tick(tick), .busy(tmr_busy), .done(tmr_done)
    );

    sr_prot_map i_prot (
        .bp(st_q.bp), .upper(addr[ADDR_W-1]),
        .region_prot(region_prot), .chip_ok(chip_ok)
    );

    assign hw_lock = st_q.lock & ~wp_n;
    assign wr_req  = cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;

    always_comb begin
        if      (cmd_wrsr) req_op = OP_WRSR;
        else if (cmd_pp)   req_op = OP_PP;
        else if (cmd_se)   req_op = OP_SE;
        else if (cmd_be)   req_op = OP_BE;
        else if (cmd_ce)   req_op = OP_CE;
        else               req_op = OP_NONE;
    end

    always_comb begin
        unique case (req_op)
            OP_WRSR:             req_ok = st_q.wel & ~hw_lock;
            OP_PP, OP_SE, OP_BE: req_ok = st_q.wel & ~region_prot;
            OP_CE:               req_ok = st_q.wel & chip_ok;
            default:             req_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (req_op)
            OP_WRSR: load_val = CNT_W'(T_WRSR);
            OP_PP:   load_val = CNT_W'(T_PP);
            OP_SE:   load_val = CNT_W'(T_SE);
            OP_BE:   load_val = CNT_W'(T_BE);
            OP_CE:   load_val = CNT_W'(T_CE);
            default: load_val = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.reject = 1'b0;
        st_d.start  = 1'b0;
        st_d.op     = OP_NONE;
        load        = 1'b0;

        if (tmr_done) begin
            st_d.wel = 1'b0;
            if (st_q.run_op == OP_WRSR) begin
                st_d.lock = st_q.pend[2];
                st_d.bp   = st_q.pend[1:0];
            end
        end

        if (tmr_busy) begin
            if (wr_req) st_d.reject = 1'b1;
        end else if (cmd_wren) begin
            st_d.wel = 1'b1;
        end else if (cmd_wrdi) begin
            st_d.wel = 1'b0;
        end else if (wr_req) begin
            if (req_ok) begin
                st_d.accept = 1'b1;
                st_d.run_op = req_op;
                load        = 1'b1;
                if (req_op == OP_WRSR) begin
                    st_d.pend = {wrsr_data[7], wrsr_data[3:2]};
                end else begin
                    st_d.start = 1'b1;
                    st_d.op    = req_op;
                end
            end else begin
                st_d.reject = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wel: 1'b0, lock: 1'b0, bp: 2'b00, pend: 3'b000,
                      run_op: OP_NONE, accept: 1'b0, reject: 1'b0,
                      start: 1'b0, op: OP_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign status      = {st_q.lock, 3'b000, st_q.bp, st_q.wel, tmr_busy};
    assign wip         = tmr_busy;
    assign cmd_accept  = st_q.accept;
    assign cmd_reject  = st_q.reject;
    assign array_start = st_q.start;
    assign array_op    = st_q.op;
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] cmds,
    input logic [7:0] status,
    input logic       wip,
    input logic       accept,
    input logic       reject,
    input logic       start,
    input logic [2:0] op
);
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmds) <= 1);                                       // R10
    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);                                       // R2
    AST_WIP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == wip);                                            // R2
    AST_ACC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));                                         // R8
    AST_ACC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $rose(wip));                                       // R8
    AST_START_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> accept && op >= 3'd2 && op <= 3'd5);                // R8
    AST_WEL_NEED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(status[1]));                                 // R3
    AST_REJ_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> status[1] == $past(status[1]));                    // R11
    AST_WEL_WIP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !status[1]);                                   // R9
    AST_CE_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd5) |-> status[3:2] == 2'b00);              // R7
endmodule

bind sr_guard sr_guard_chk i_chk (
    .clk(clk), .rst_n(rst_n),
    .cmds({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce}),
    .status(status), .wip(wip), .accept(cmd_accept), .reject(cmd_reject),
    .start(array_start), .op(array_op)
);

// File: tb/test_sr_guard.sv
module test_sr_guard;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_wren = 0, c_wrdi = 0, c_wrsr = 0, c_pp = 0, c_se = 0, c_be = 0, c_ce = 0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wp_n = 1'b1;
    logic [7:0]  status;
    logic        acc, rej, wip, strt;
    logic [2:0]  op;

    int checks = 0;
    int fails  = 0;

    logic       m_wel = 0, m_lock = 0;
    logic [1:0] m_bp = 0;

    always #5 clk = ~clk;

    sr_guard #(.ADDR_W(17), .TICK_DIV(DIV), .T_WRSR(5), .T_PP(2),
               .T_SE(4), .T_BE(6), .T_CE(7)) i_sr_guard (
        .clk(clk), .rst_n(rst_n), .cmd_wren(c_wren), .cmd_wrdi(c_wrdi),
        .cmd_wrsr(c_wrsr), .cmd_pp(c_pp), .cmd_se(c_se), .cmd_be(c_be),
        .cmd_ce(c_ce), .addr(addr), .wrsr_data(wdata), .wp_n(wp_n),
        .status(status), .cmd_accept(acc), .cmd_reject(rej), .wip(wip),
        .array_start(strt), .array_op(op)
    );

    // command codes: 0 wren, 1 wrdi, 2 wrsr, 3 pp, 4 se, 5 be, 6 ce
    function automatic int dur(int c);
        case (c)
            2: return 5; 3: return 2; 4: return 4; 5: return 6; default: return 7;
        endcase
    endfunction

    function automatic logic prot(logic [1:0] bp, logic [16:0] a);
        return (bp == 2'b00) ? 1'b0 : (bp == 2'b01) ? a[16] : 1'b1;
    endfunction

    function automatic logic ok(int c, logic [16:0] a, logic w);
        if (!m_wel) return 1'b0;
        if (c == 2) return !(m_lock && !w);
        if (c == 6) return m_bp == 2'b00;
        return !prot(m_bp, a);
    endfunction

    function automatic logic [7:0] exp_st();
        return {m_lock, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(int c, logic v);
        case (c)
            0: c_wren = v; 1: c_wrdi = v; 2: c_wrsr = v; 3: c_pp = v;
            4: c_se = v;   5: c_be = v;   default: c_ce = v;
        endcase
    endtask

    // issue one command from idle and check everything it should cause
    task automatic issue(int c, logic [16:0] a, logic [7:0] d);
        logic e;
        int   n;
        e = (c >= 2) ? ok(c, a, wp_n) : 1'b0;
        addr = a; wdata = d; drive(c, 1'b1);
        @(negedge clk);
        drive(c, 1'b0);
        if (c == 0) begin m_wel = 1; chk("R2 wren", status, exp_st()); end
        else if (c == 1) begin m_wel = 0; chk("R2 wrdi", status, exp_st()); end
        else if (!e) begin
            chk("R3 reject", {acc, rej, strt}, 3'b010);
            chk("R11 status kept", status, exp_st());
        end else begin
            chk("R8 accept", {acc, rej, wip}, 3'b101);
            chk("R8 start", {strt, op}, (c == 2) ? 4'h0 : {1'b1, 3'(c - 1)});
            n = 0;
            while (wip && n < 1000) begin n++; @(negedge clk); end
            chk("R9 busy length", n, dur(c) * DIV);
            m_wel = 0;
            if (c == 2) begin m_lock = d[7]; m_bp = d[3:2]; end
            chk("R9 R4 status after", status, exp_st());
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1 reset", {status, acc, rej, wip, strt}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {status, acc, rej, wip, strt}, 12'h000);

        issue(3, 17'h00100, 8'h00);           // R3 no WEL
        issue(0, 0, 0);
        issue(2, 0, 8'hFF);                   // R4: only 7,3,2 -> 8C
        chk("R4 value", status, 8'h8C);
        issue(0, 0, 0);
        wp_n = 1'b0;
        issue(2, 0, 8'h00);                   // R5 hardware lock rejects
        chk("R5 wel kept R11", status, 8'h8E);
        wp_n = 1'b1;
        issue(2, 0, 8'h04);                   // R5 lock with wp_n high accepted
        chk("R6 bp01", status, 8'h04);
        issue(0, 0, 0);
        issue(3, 17'h10000, 0);               // R6 upper half protected
        issue(3, 17'h00100, 0);               // R6 lower half allowed
        issue(0, 0, 0);
        issue(6, 0, 0);                       // R7 chip erase refused
        // R10: commands during busy
        issue(1, 0, 0);
        issue(0, 0, 0);
        addr = 17'h00000; c_se = 1; @(negedge clk); c_se = 0;
        chk("R10 busy", wip, 1'b1);
        c_wrdi = 1; @(negedge clk); c_wrdi = 0;
        chk("R10 wrdi ignored", status[1], 1'b1);
        c_be = 1; @(negedge clk); c_be = 0;
        chk("R10 reject while busy", {acc, rej, strt}, 3'b010);
        while (wip) @(negedge clk);
        chk("R9 wel cleared", status, 8'h04);
        m_wel = 0;
        issue(0, 0, 0);
        issue(2, 0, 8'h00);
        issue(0, 0, 0);
        issue(6, 0, 0);                       // R7 chip erase allowed with bp 00

        for (int i = 0; i < 250; i++) begin
            int c;
            c = int'($urandom_range(0, 9));
            if (c > 6) c = 0;
            wp_n = 1'($urandom_range(0, 1));
            issue(c, 17'($urandom), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule